// File: doc/BRIEF.md
# Periodic Refresh Scheduler with Postponement

This block sits beside a DDR SDRAM command controller and decides when an auto-refresh is owed. A free-running interval timer produces one refresh obligation per programmed period (1040 cycles by default, about 7.8 us at 133 MHz). Obligations collect in a debt counter. The scheduler raises a refresh request while the debt is non-zero, the controller is not busy, and no timing wait is running. The controller answers with a grant in the cycle it issues the refresh.

While the controller is busy, refreshes are postponed, up to eight of them. When the debt reaches that limit, the urgent flag rises and the request ignores the busy input. After each granted refresh, the scheduler closes the command window for the refresh recovery time. It also handles self-refresh: on entry it drops the clock enable and clears the debt. On exit it holds non-read commands and reads back for two separate recovery periods.

Top module: `rfs_sched`

## Requirements
- R1: After reset the debt is 0, request and urgent are low, the clock enable is high, and both command permissions are high.
- R2: While not in self-refresh, the debt rises by one every INTERVAL_CYC cycles. The first rise is INTERVAL_CYC clock edges after reset is released or self-refresh is left.
- R3: The debt never exceeds MAX_DEBT and never goes below 0. A tick that arrives at MAX_DEBT without a grant leaves it at MAX_DEBT.
- R4: The request is high exactly when the debt is non-zero, non-read commands are permitted, and either busy is low or urgent is high.
- R5: Urgent is high exactly when the debt equals MAX_DEBT. With busy high and urgent high, the request stays high.
- R6: A grant taken while the request is high lowers the debt by one (or leaves it unchanged if a tick lands in the same cycle). It also drops both permissions for the following TRFC_CYC-1 cycles, so the next refresh can come no earlier than TRFC_CYC cycles later.
- R7: An accepted self-refresh entry drives the clock enable low, clears the debt, lowers the request and both permissions, and stops the interval timer until exit.
- R8: Self-refresh exit raises the clock enable at once. Non-read permission returns XSNR_CYC clock edges after the exit edge, and read permission returns XSRD_CYC edges after it.
- R9: A self-refresh entry request is ignored while non-read commands are not permitted, or when a grant is taken in the same cycle.
- R10: A grant while the request is low has no effect on the debt or on the permissions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busy_i | input | 1 | Controller busy; postpones non-urgent refreshes |
| ref_gnt_i | input | 1 | Controller issues the refresh this cycle |
| sr_enter_i | input | 1 | Request to enter self-refresh |
| sr_exit_i | input | 1 | Request to leave self-refresh |
| ref_req_o | output | 1 | Refresh wanted |
| ref_urgent_o | output | 1 | Debt at its limit; busy is overridden |
| debt_o | output | $clog2(MAX_DEBT+1) | Refreshes currently owed |
| cke_o | output | 1 | Clock enable to the memory; low in self-refresh |
| allow_nonread_o | output | 1 | Activate, refresh and other non-read commands permitted |
| allow_read_o | output | 1 | Read commands permitted |

## Verification
The bench builds the scheduler with a 20-cycle interval, a 4-cycle refresh recovery, a 5-cycle non-read exit wait and a 12-cycle read exit wait. The debt limit stays at its default of 8. With these short values the debt reaches saturation within a couple of hundred cycles while busy is held. The cases where a tick and a grant fall in the same cycle then occur many times within a short run. The whole exit sequence, with its two distinct permission edges, can also be counted edge by edge.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

  typedef enum logic {
    PWR_ACTIVE = 1'b0,
    PWR_SELF   = 1'b1
  } pwr_state_e;

  // next debt value: add a tick, remove a taken refresh, clamp at cap
  function automatic int unsigned debt_step(input int unsigned cur,
                                            input logic tick,
                                            input logic take,
                                            input int unsigned cap);
    int unsigned nxt;
    nxt = cur + (tick ? 1 : 0);
    if (take && nxt != 0) nxt = nxt - 1;
    if (nxt > cap) nxt = cap;
    return nxt;
  endfunction

  // width needed to hold values 0..max_val
  function automatic int unsigned width_for(input int unsigned max_val);
    int unsigned w;
    w = 1;
    while ((1 << w) <= max_val) w = w + 1;
    return w;
  endfunction

endpackage

// File: rtl/rfs_tick_gen.sv
module rfs_tick_gen #(
  parameter int unsigned INTERVAL_CYC = 1040
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int unsigned CW = rfs_pkg::width_for(INTERVAL_CYC);
  localparam logic [CW-1:0] LAST = CW'(INTERVAL_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign tick = run && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (!run)     cnt_q <= '0;
    else if (tick)     cnt_q <= '0;
    else               cnt_q <= cnt_q + 1'b1;
  end

  // ticks are separated by the full interval
  assert_tick_isolated_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && INTERVAL_CYC > 1) |=> !tick);

  assert_stopped_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));

endmodule

// File: rtl/rfs_debt.sv
module rfs_debt #(
  parameter int unsigned MAX_DEBT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic take,
  input  logic clear,
  output logic [rfs_pkg::width_for(MAX_DEBT)-1:0] debt,
  output logic urgent
);
  localparam int unsigned DW = rfs_pkg::width_for(MAX_DEBT);

  logic [DW-1:0] debt_q;
  logic [DW-1:0] debt_d;

  always_comb begin
    debt_d = DW'(rfs_pkg::debt_step(int'(debt_q), tick, take, MAX_DEBT));
    if (clear) debt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) debt_q <= '0;
    else        debt_q <= debt_d;
  end

  assign debt   = debt_q;
  assign urgent = (debt_q == DW'(MAX_DEBT));

  assert_debt_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
    debt_q <= DW'(MAX_DEBT));

  assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (debt_q != '0));

  assert_saturate_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (urgent && tick && !take && !clear) |=> urgent);

  assert_tick_adds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !take && !clear && !urgent) |=> (debt_q == $past(debt_q) + 1'b1));

endmodule

// File: rtl/rfs_wait_cnt.sv
module rfs_wait_cnt #(
  parameter int unsigned WAIT_W   = 8,
  parameter int unsigned LOAD_VAL = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy
);
  logic [WAIT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= WAIT_W'(LOAD_VAL);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);

  assert_wait_armed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (load && LOAD_VAL > 0) |=> busy);

endmodule

// File: rtl/rfs_sched.sv
module rfs_sched #(
  parameter int unsigned INTERVAL_CYC = 1040,
  parameter int unsigned TRFC_CYC     = 10,
  parameter int unsigned MAX_DEBT     = 8,
  parameter int unsigned XSNR_CYC     = 10,
  parameter int unsigned XSRD_CYC     = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_i,
  input  logic ref_gnt_i,
  input  logic sr_enter_i,
  input  logic sr_exit_i,
  output logic ref_req_o,
  output logic ref_urgent_o,
  output logic [$clog2(MAX_DEBT+1)-1:0] debt_o,
  output logic cke_o,
  output logic allow_nonread_o,
  output logic allow_read_o
);
  import rfs_pkg::*;

  localparam int unsigned DW      = width_for(MAX_DEBT);
  localparam int unsigned MAXWAIT = (TRFC_CYC > XSNR_CYC)
                                    ? ((TRFC_CYC > XSRD_CYC) ? TRFC_CYC : XSRD_CYC)
                                    : ((XSNR_CYC > XSRD_CYC) ? XSNR_CYC : XSRD_CYC);
  localparam int unsigned WAIT_W  = width_for(MAXWAIT);
  localparam int unsigned NWAIT   = 3;   // 0: refresh recovery, 1: non-read exit, 2: read exit

  pwr_state_e pwr_q;
  logic       in_sr;
  logic       tick;
  logic       take;
  logic       enter;
  logic       leave;
  logic       urgent;
  logic       allow_nr;
  logic       allow_rd;
  logic       req;
  logic [DW-1:0]    debt;
  logic [NWAIT-1:0] wait_load;
  logic [NWAIT-1:0] wait_busy;

  assign in_sr    = (pwr_q == PWR_SELF);
  assign allow_nr = !in_sr && !wait_busy[0] && !wait_busy[1];
  assign allow_rd = allow_nr && !wait_busy[2];
  assign req      = (debt != '0) && allow_nr && (!busy_i || urgent);
  assign take     = req && ref_gnt_i;
  assign enter    = !in_sr && sr_enter_i && allow_nr && !take;
  assign leave    = in_sr && sr_exit_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pwr_q <= PWR_ACTIVE;
    else if (enter) pwr_q <= PWR_SELF;
    else if (leave) pwr_q <= PWR_ACTIVE;
  end

  rfs_tick_gen #(.INTERVAL_CYC(INTERVAL_CYC)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (!in_sr && !enter),
    .tick (tick)
  );

  rfs_debt #(.MAX_DEBT(MAX_DEBT)) u_debt (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .take  (take),
    .clear (enter),
    .debt  (debt),
    .urgent(urgent)
  );

  assign wait_load[0] = take;
  assign wait_load[1] = leave;
  assign wait_load[2] = leave;

  for (genvar g = 0; g < NWAIT; g++) begin : g_wait
    localparam int unsigned LV = (g == 0) ? TRFC_CYC - 1
                               : (g == 1) ? XSNR_CYC : XSRD_CYC;
    rfs_wait_cnt #(.WAIT_W(WAIT_W), .LOAD_VAL(LV)) u_wait (
      .clk  (clk),
      .rst_n(rst_n),
      .load (wait_load[g]),
      .busy (wait_busy[g])
    );
  end

  assign ref_req_o       = req;
  assign ref_urgent_o    = urgent;
  assign debt_o          = ($clog2(MAX_DEBT+1))'(debt);
  assign cke_o           = !in_sr;
  assign allow_nonread_o = allow_nr;
  assign allow_read_o    = allow_rd;

  assert_busy_defers_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && !ref_urgent_o) |-> !ref_req_o);

  assert_urgent_forces_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_urgent_o && allow_nonread_o) |-> ref_req_o);

  assert_recovery_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && TRFC_CYC > 1) |=> !allow_nonread_o);

  assert_self_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cke_o |-> (!ref_req_o && !allow_nonread_o && !allow_read_o));

  assert_self_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    enter |=> (!cke_o && debt_o == '0));

  assert_read_subset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    allow_read_o |-> allow_nonread_o);

  assert_exit_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    leave |=> (cke_o && !allow_read_o));

  assert_entry_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cke_o && !allow_nonread_o) |=> cke_o);

  assert_stray_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_gnt_i && !ref_req_o && cke_o && allow_nonread_o) |=> allow_nonread_o);

endmodule

// File: tb/tb_rfs_sched.sv
module tb_rfs_sched;
  localparam int INTERVAL = 20;
  localparam int TRFC     = 4;
  localparam int MAXD     = 8;
  localparam int XSNR     = 5;
  localparam int XSRD     = 12;
  localparam int DW       = $clog2(MAXD + 1);

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, busy, gnt, sr_en, sr_ex;
  logic req, urg, cke, anr, ard;
  logic [DW-1:0] debt;

  rfs_sched #(
    .INTERVAL_CYC(INTERVAL), .TRFC_CYC(TRFC), .MAX_DEBT(MAXD),
    .XSNR_CYC(XSNR), .XSRD_CYC(XSRD)
  ) dut (
    .clk(clk), .rst_n(rst_n), .busy_i(busy), .ref_gnt_i(gnt),
    .sr_enter_i(sr_en), .sr_exit_i(sr_ex), .ref_req_o(req),
    .ref_urgent_o(urg), .debt_o(debt), .cke_o(cke),
    .allow_nonread_o(anr), .allow_read_o(ard)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference state
  int  m_timer, m_debt, m_rfc, m_xsnr, m_xsrd;
  bit  m_sr;

  function automatic bit e_anr();
    return !m_sr && m_rfc == 0 && m_xsnr == 0;
  endfunction
  function automatic bit e_ard();
    return e_anr() && m_xsrd == 0;
  endfunction
  function automatic bit e_urg();
    return m_debt == MAXD;
  endfunction
  function automatic bit e_req(input bit b);
    return m_debt > 0 && e_anr() && (!b || e_urg());
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_timer = 0; m_debt = 0; m_rfc = 0; m_xsnr = 0; m_xsrd = 0; m_sr = 0;
    end else begin
      bit acc, ent, ext, tk;
      int d;
      acc = gnt && e_req(busy);
      ent = !m_sr && sr_en && e_anr() && !acc;
      ext = m_sr && sr_ex;
      tk  = !m_sr && !ent && m_timer == INTERVAL - 1;
      if (m_rfc > 0)  m_rfc--;
      if (m_xsnr > 0) m_xsnr--;
      if (m_xsrd > 0) m_xsrd--;
      if (acc) m_rfc = TRFC - 1;
      if (ent) begin
        m_sr = 1; m_debt = 0; m_timer = 0;
      end else if (m_sr) begin
        m_timer = 0;
        if (ext) begin m_sr = 0; m_xsnr = XSNR; m_xsrd = XSRD; end
      end else begin
        m_timer = tk ? 0 : m_timer + 1;
        d = m_debt + (tk ? 1 : 0) - (acc ? 1 : 0);
        m_debt = (d > MAXD) ? MAXD : d;
      end
    end
  end

  // cycle-by-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 debt", int'(debt), m_debt);
      chk("R5 urgent", int'(urg), int'(e_urg()));
      chk("R4 request", int'(req), int'(e_req(busy)));
      chk("R6 allow_nonread", int'(anr), int'(e_anr()));
      chk("R8 allow_read", int'(ard), int'(e_ard()));
      chk("R7 cke", int'(cke), int'(!m_sr));
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic summary();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int n;
    rst_n = 0; busy = 0; gnt = 0; sr_en = 0; sr_ex = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1 debt", int'(debt), 0);
    chk("R1 req", int'(req), 0);
    chk("R1 urgent", int'(urg), 0);
    chk("R1 cke", int'(cke), 1);
    chk("R1 permissions", int'(anr && ard), 1);

    // postpone until saturation
    busy = 1;
    repeat (MAXD * INTERVAL + 30) step();
    @(negedge clk);
    chk("R3 saturated debt", int'(debt), MAXD);
    chk("R5 urgent under busy", int'(urg), 1);
    chk("R5 request under busy", int'(req), 1);

    // one urgent grant, then recovery window
    step(); gnt = 1;
    step(); gnt = 0;
    @(negedge clk);
    chk("R6 recovery closes window", int'(anr), 0);
    chk("R4 busy defers after urgency ends", int'(req), 0);

    // drain with handshake
    busy = 0;
    for (int i = 0; i < 80; i++) begin step(); gnt = req; end
    gnt = 0;
    busy = 1;
    repeat (TRFC + 1) step();

    // stray grant while request low
    gnt = 1; step(); gnt = 0;
    @(negedge clk);
    chk("R10 stray grant ignored", int'(anr), 1);

    // entry during recovery is ignored
    repeat (INTERVAL) step();
    busy = 0;
    while (!req) step();
    gnt = 1; step(); gnt = 0;
    sr_en = 1; step(); sr_en = 0;
    @(negedge clk);
    chk("R9 entry ignored", int'(cke), 1);
    repeat (TRFC) step();
    sr_en = 1; step(); sr_en = 0;
    @(negedge clk);
    chk("R7 entry cke", int'(cke), 0);
    chk("R7 entry debt", int'(debt), 0);
    repeat (3 * INTERVAL) step();
    @(negedge clk);
    chk("R7 timer frozen", int'(debt), 0);

    // exit waits
    sr_ex = 1; step(); sr_ex = 0;
    n = 0;
    while (!anr && n < 1000) begin step(); n++; end
    chk("R8 non-read wait", n, XSNR);
    while (!ard && n < 1000) begin step(); n++; end
    chk("R8 read wait", n, XSRD);

    // random traffic
    for (int i = 0; i < 600; i++) begin
      step();
      busy = ($urandom_range(0, 3) != 0);
      gnt  = req && ($urandom_range(0, 1) == 1);
    end
    gnt = 0; busy = 0;
    repeat (2) step();
    summary();
  end
endmodule